// File: doc/BRIEF.md
# Second-Order Delta-Sigma Audio Modulator

This block turns signed 16-bit audio samples into a one-wire pulse-density stream for mono audio output, ready for a simple external low-pass filter. A free-running tick enable paces everything. Each output bit lasts a fixed number of ticks: four or eight, chosen by `speed_i`. New samples are taken once per sample period, and that period is set in ticks by `period_i`. A second-order noise-shaping loop with saturating integrators decides each output bit.

With `mode_i` high, the block interpolates linearly from the previous value to each new sample across the sample period. An iterative divider scales the per-tick step by the period length, so the interpolated value reaches the new sample in one period whatever the period is. The same mode also shapes every output bit so that it contains one rising and one falling edge. With `mode_i` low, the block holds each sample unchanged until the next one (zeroth order) and drives each output bit flat for its whole duration. Modulation begins on the first tick after `en_i` rises. Dropping `en_i` clears all state.

Top module: `dsm_audio_mod`

## Requirements
- R1: `pdm_o` is low while `rst_ni` is low, and from the first clock edge after `en_i` is sampled low.
- R2: With `mode_i`=0 and a constant `sample_i`=x (two's complement), the fraction of time `pdm_o` is high settles to (x+32768)/65536 within 0.02.
- R3: Each output bit spans N ticks, with N=4 for `speed_i`=0 and N=8 for `speed_i`=1. With `mode_i`=0, every run of constant `pdm_o` lasts a whole number of bits.
- R4: `sample_i` is captured only on the tick at which the sample counter equals `period_i`. The counter starts at 0 on the first tick after enable, so captures occur every `period_i`+1 ticks. Values present on other ticks have no effect. `period_i` must be at least 31.
- R5: With `mode_i`=1 and a constant input of density d=(x+32768)/65536, the high-time fraction settles to 1/N + d·(N-2)/N within 0.02.
- R6: With `mode_i`=1, the high-time fraction stays between 1/N and (N-1)/N.
- R7: With `mode_i`=1, every bit is high in its first tick and low in its last tick. A 1 bit is high in all ticks but the last. A 0 bit is high only in its first tick. This gives exactly one rising edge per bit.
- R8: Disabling clears the integrators, the interpolator, the divider and the counters, so an identical re-enable reproduces the same output sequence.
- R9: Cycles without `tick_i` advance no state, so `pdm_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears all state |
| tick_i | input | 1 | Tick enable that paces the modulator |
| period_i | input | 16 | Sample period minus one, in ticks |
| speed_i | input | 1 | Bit length: 0 = 4 ticks, 1 = 8 ticks |
| mode_i | input | 1 | 1 = linear interpolation and edge shaping, 0 = hold and flat bits |
| sample_i | input | 16 | Signed audio sample |
| pdm_o | output | 1 | Pulse-density output |

## Verification
A wrong integrator or feedback value shows up as a shifted long-term duty cycle. That shift becomes clear only after many hundreds of bits, so density is measured over windows of thousands of ticks after a settling time. Faults in the bit counter, the shaper or the sample-capture point show up within a single bit or a single sample period. They appear as run lengths that are not a whole number of bits, a wrong count of rising edges, or a density taken from off-strobe sample values. State that survives a disable shows up as soon as the block is re-enabled, as a difference between two runs that should be identical.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int unsigned DEF_SMP_W  = 16;
  localparam int unsigned DEF_FRAC_W = 8;
  localparam int unsigned DEF_ACC_W  = 22;
  localparam int unsigned DEF_PER_W  = 16;
  localparam int unsigned SUB_W      = 3;
  typedef logic [SUB_W-1:0] sub_t;
endpackage

// File: rtl/dsm_phase_gen.sv
module dsm_phase_gen
  import dsm_pkg::*;
#(
  parameter int unsigned PER_W = DEF_PER_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             speed_i,
  input  logic [PER_W-1:0] period_i,
  output sub_t             sub_o,
  output logic             sub_last_o,
  output logic             bit_upd_o,
  output logic             smp_stb_o
);
  sub_t             sub_q;
  sub_t             sub_max;
  logic [PER_W-1:0] cnt_q;
  logic             adv;
  logic             cnt_end;

  assign sub_max    = speed_i ? sub_t'(7) : sub_t'(3);
  assign sub_last_o = (sub_q >= sub_max);
  assign adv        = en_i & tick_i;
  assign cnt_end    = (cnt_q >= period_i);
  assign bit_upd_o  = adv & sub_last_o;
  assign smp_stb_o  = adv & cnt_end;
  assign sub_o      = sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      cnt_q <= '0;
    end else if (!en_i) begin
      sub_q <= '0;
      cnt_q <= '0;
    end else if (tick_i) begin
      sub_q <= sub_last_o ? '0 : sub_q + sub_t'(1);
      cnt_q <= cnt_end ? '0 : cnt_q + PER_W'(1);
    end
  end

  // bits last at least four ticks
  assert_upd_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_upd_o |=> !bit_upd_o);

  assert_no_tick_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !tick_i |=> $stable(sub_o));
endmodule

// File: rtl/dsm_interp.sv
module dsm_interp
  import dsm_pkg::*;
#(
  parameter int unsigned SMP_W  = DEF_SMP_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  parameter int unsigned PER_W  = DEF_PER_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    tick_i,
  input  logic                    interp_en_i,
  input  logic                    smp_stb_i,
  input  logic [PER_W-1:0]        period_i,
  input  logic signed [SMP_W-1:0] sample_i,
  output logic signed [SMP_W-1:0] x_o
);
  localparam int unsigned VW = SMP_W + FRAC_W;
  localparam int unsigned MW = VW;
  localparam int unsigned DW = PER_W + 1;
  localparam int unsigned CW = $clog2(MW + 1);

  logic signed [VW-1:0] v_q, step_q, target;
  logic signed [VW:0]   diff;
  logic [MW-1:0]        mag;
  logic [MW-1:0]        quo_q;
  logic [DW-1:0]        rem_q, div_q;
  logic [DW:0]          shifted;
  logic                 fits;
  logic [CW-1:0]        cnt_q;
  logic                 busy_q, neg_q;

  assign target  = {sample_i, {FRAC_W{1'b0}}};
  assign diff    = {target[VW-1], target} - {v_q[VW-1], v_q};
  assign mag     = diff[VW] ? MW'(-diff) : diff[MW-1:0];
  assign shifted = {rem_q, quo_q[MW-1]};
  assign fits    = (shifted >= {1'b0, div_q});
  assign x_o     = v_q[VW-1:FRAC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0; step_q <= '0; quo_q <= '0; rem_q <= '0;
      div_q <= '0; cnt_q <= '0; busy_q <= 1'b0; neg_q <= 1'b0;
    end else if (!en_i) begin
      v_q <= '0; step_q <= '0; quo_q <= '0; rem_q <= '0;
      div_q <= '0; cnt_q <= '0; busy_q <= 1'b0; neg_q <= 1'b0;
    end else begin
      if (smp_stb_i) begin
        step_q <= '0;
        if (!interp_en_i) begin
          v_q    <= target;
          busy_q <= 1'b0;
        end else begin
          // step = (target - v) / (period + 1): gain compensation
          neg_q  <= diff[VW];
          quo_q  <= mag;
          rem_q  <= '0;
          div_q  <= {1'b0, period_i} + DW'(1);
          cnt_q  <= CW'(MW);
          busy_q <= 1'b1;
        end
      end else begin
        if (tick_i && interp_en_i) v_q <= v_q + step_q;
        if (busy_q) begin
          if (cnt_q != '0) begin
            rem_q <= fits ? DW'(shifted - {1'b0, div_q}) : shifted[DW-1:0];
            quo_q <= {quo_q[MW-2:0], fits};
            cnt_q <= cnt_q - CW'(1);
          end else begin
            step_q <= neg_q ? -quo_q : quo_q;
            busy_q <= 1'b0;
          end
        end
      end
    end
  end

  assert_hold_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && smp_stb_i && !interp_en_i |=> x_o == $past(sample_i));

  assert_hold_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !smp_stb_i && !interp_en_i |=> $stable(x_o));
endmodule

// File: rtl/dsm_core.sv
module dsm_core
  import dsm_pkg::*;
#(
  parameter int unsigned SMP_W = DEF_SMP_W,
  parameter int unsigned ACC_W = DEF_ACC_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    upd_i,
  input  logic signed [SMP_W-1:0] x_i,
  output logic                    bit_o
);
  localparam int unsigned EW = ACC_W + 2;
  localparam logic signed [EW-1:0] A_MAX = EW'((64'sd1 <<< (ACC_W-1)) - 64'sd1);
  localparam logic signed [EW-1:0] A_MIN = EW'(-(64'sd1 <<< (ACC_W-1)));
  localparam logic signed [EW-1:0] FB    = EW'(64'sd1 <<< (SMP_W-1));

  logic signed [ACC_W-1:0] i1_q, i2_q, i1_n, i2_n;
  logic signed [EW-1:0]    fb, s1, s2;
  logic                    y, bit_q;

  function automatic logic signed [ACC_W-1:0] clamp(input logic signed [EW-1:0] s);
    if (s > A_MAX)      return A_MAX[ACC_W-1:0];
    else if (s < A_MIN) return A_MIN[ACC_W-1:0];
    else                return s[ACC_W-1:0];
  endfunction

  // quantize the second integrator before its update: NTF = (1 - z^-1)^2
  assign y    = ~i2_q[ACC_W-1];
  assign fb   = y ? FB : -FB;
  assign s1   = EW'(i1_q) + EW'(x_i) - fb;
  assign i1_n = clamp(s1);
  assign s2   = EW'(i2_q) + EW'(i1_n) - fb;
  assign i2_n = clamp(s2);
  assign bit_o = bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i1_q <= '0; i2_q <= '0; bit_q <= 1'b0;
    end else if (!en_i) begin
      i1_q <= '0; i2_q <= '0; bit_q <= 1'b0;
    end else if (upd_i) begin
      i1_q  <= i1_n;
      i2_q  <= i2_n;
      bit_q <= y;
    end
  end

  assert_acc_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (i1_q == '0) && (i2_q == '0) && !bit_o);

  assert_bit_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !upd_i |=> $stable(bit_o));
endmodule

// File: rtl/dsm_shaper.sv
module dsm_shaper
  import dsm_pkg::*;
(
  input  logic run_i,
  input  logic shape_i,
  input  logic bit_i,
  input  sub_t sub_i,
  input  logic sub_last_i,
  output logic pdm_o
);
  logic shaped;

  assign shaped = bit_i ? !sub_last_i : (sub_i == '0);
  assign pdm_o  = run_i & (shape_i ? shaped : bit_i);
endmodule

// File: rtl/dsm_audio_mod.sv
module dsm_audio_mod
  import dsm_pkg::*;
#(
  parameter int unsigned PER_W  = DEF_PER_W,
  parameter int unsigned SMP_W  = DEF_SMP_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  parameter int unsigned ACC_W  = DEF_ACC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             speed_i,
  input  logic             mode_i,
  input  logic [SMP_W-1:0] sample_i,
  output logic             pdm_o
);
  sub_t                    sub;
  logic                    sub_last, bit_upd, smp_stb, bit_val, run_q;
  logic signed [SMP_W-1:0] x_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i;
  end

  dsm_phase_gen #(.PER_W(PER_W)) i_phase (
    .clk_i, .rst_ni, .en_i, .tick_i, .speed_i, .period_i,
    .sub_o(sub), .sub_last_o(sub_last), .bit_upd_o(bit_upd), .smp_stb_o(smp_stb)
  );

  dsm_interp #(.SMP_W(SMP_W), .FRAC_W(FRAC_W), .PER_W(PER_W)) i_interp (
    .clk_i, .rst_ni, .en_i, .tick_i, .interp_en_i(mode_i), .smp_stb_i(smp_stb),
    .period_i, .sample_i($signed(sample_i)), .x_o(x_val)
  );

  dsm_core #(.SMP_W(SMP_W), .ACC_W(ACC_W)) i_core (
    .clk_i, .rst_ni, .en_i, .upd_i(bit_upd), .x_i(x_val), .bit_o(bit_val)
  );

  dsm_shaper i_shaper (
    .run_i(run_q), .shape_i(mode_i), .bit_i(bit_val), .sub_i(sub),
    .sub_last_i(sub_last), .pdm_o
  );

  assert_idle_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pdm_o);

  assert_first_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && mode_i && (sub == '0) |-> pdm_o);

  assert_last_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && mode_i && sub_last |-> !pdm_o);
endmodule

// File: tb/test_dsm_audio_mod.sv
module test_dsm_audio_mod;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, tick = 1'b0, speed = 1'b0, mode = 1'b0;
  logic [15:0] period = 16'd63;
  logic [15:0] sample = 16'd0;
  logic        pdm;
  int          n_chk = 0, n_fail = 0;

  localparam int WARM = 1500;
  localparam int MEAS = 8000;

  typedef struct packed {
    logic signed [15:0] smp;
    logic               spd;
    logic               mod;
    logic [15:0]        per;
    logic [1:0]         div;
    logic [11:0]        exp_pm;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{16'sd0,      1'b0, 1'b0, 16'd63,  2'd1, 12'd500},
    '{16'sd16384,  1'b1, 1'b0, 16'd63,  2'd1, 12'd750},
    '{-16'sd16384, 1'b0, 1'b1, 16'd63,  2'd1, 12'd375},
    '{16'sd16384,  1'b1, 1'b1, 16'd255, 2'd1, 12'd688},
    '{-16'sd24576, 1'b1, 1'b0, 16'd63,  2'd2, 12'd125},
    '{16'sd0,      1'b1, 1'b1, 16'd31,  2'd1, 12'd500},
    '{16'sd24000,  1'b1, 1'b1, 16'd63,  2'd1, 12'd775},
    '{-16'sd24000, 1'b0, 1'b1, 16'd63,  2'd1, 12'd317},
    '{16'sd8192,   1'b0, 1'b1, 16'd100, 2'd3, 12'd563}
  };

  always #2 clk = ~clk;

  dsm_audio_mod i_dsm_audio_mod (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick), .period_i(period),
    .speed_i(speed), .mode_i(mode), .sample_i(sample), .pdm_o(pdm)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    en = 1'b0; tick = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int hi = 0, rises = 0, ticks = 0, bad_runs = 0, run_len = 0, n, dens;
    bit prev = 1'b0, started = 1'b0;
    idle(4);
    n = v.spd ? 8 : 4;
    sample = v.smp; speed = v.spd; mode = v.mod; period = v.per;
    en = 1'b1; tick = 1'b1;
    for (int c = 1; c < WARM + MEAS; c++) begin
      @(negedge clk);
      if (c > WARM) begin
        if (pdm) hi++;
        if (pdm && !prev) rises++;
        if (pdm != prev) begin
          if (started && (run_len % (n * v.div) != 0)) bad_runs++;
          started = 1'b1;
          run_len = 0;
        end
        run_len++;
        if (tick) ticks++;
      end
      prev = pdm;
      tick = (c % v.div) == 0;
    end
    dens = hi * 1000 / (MEAS - 1);
    if (!v.mod) begin
      check(dens >= int'(v.exp_pm) - 20 && dens <= int'(v.exp_pm) + 20, "R2 density", dens, int'(v.exp_pm));
      check(bad_runs == 0, "R3 run length multiple of bit", bad_runs, 0);
    end else begin
      check(dens >= int'(v.exp_pm) - 20 && dens <= int'(v.exp_pm) + 20, "R5 density", dens, int'(v.exp_pm));
      check(dens >= 1000 / n - 5 && dens <= 1000 * (n - 1) / n + 5, "R6 duty bound", dens, int'(v.exp_pm));
      check(rises >= ticks / n - 2 && rises <= ticks / n + 2, "R7 one rise per bit", rises, ticks / n);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int hi, same;
    bit hold, stable_ok;
    bit rec [300];
    repeat (3) @(negedge clk);
    check(pdm == 1'b0, "R1 reset low", int'(pdm), 0);
    rst_n = 1'b1;

    foreach (VECS[i]) run_vec(VECS[i]);

    // R1: output low right after disable
    idle(1);
    check(pdm == 1'b0, "R1 low after disable", int'(pdm), 0);

    // R4: high value only on capture ticks, low value elsewhere
    idle(4);
    mode = 1'b0; speed = 1'b0; period = 16'd63;
    hi = 0;
    en = 1'b1; tick = 1'b1; sample = (1 % 64 == 0) ? 16'sd16384 : -16'sd16384;
    for (int c = 1; c < WARM + MEAS; c++) begin
      @(negedge clk);
      if (c > WARM && pdm) hi++;
      sample = ((c + 1) % 64 == 0) ? 16'sd16384 : -16'sd16384;
    end
    check(hi * 1000 / (MEAS - 1) >= 730 && hi * 1000 / (MEAS - 1) <= 770,
          "R4 capture on period tick", hi * 1000 / (MEAS - 1), 750);

    // R9: no tick, no change
    @(negedge clk);
    mode = 1'b1; speed = 1'b1; sample = 16'sd5000; tick = 1'b0;
    @(negedge clk);
    hold = pdm; stable_ok = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (pdm != hold) stable_ok = 1'b0;
    end
    check(stable_ok, "R9 frozen without tick", int'(stable_ok), 1);

    // R8: identical re-enable reproduces the sequence
    idle(6);
    mode = 1'b1; speed = 1'b0; period = 16'd47; sample = 16'sd12000;
    en = 1'b1; tick = 1'b1;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      rec[c] = pdm;
    end
    idle(6);
    en = 1'b1; tick = 1'b1;
    same = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (pdm == rec[c]) same++;
    end
    check(same == 300, "R8 restart reproducible", same, 300);
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule